// File: doc/BRIEF.md
# Pseudo-Random Generator and CRC16 Engine

This block holds one 16-bit linear-feedback shift register behind a small byte-wide register interface. The same register works two ways. As a pseudo-random source, software seeds it through the low data register and reads numbers back a byte at a time. In normal mode, every read of the high data byte moves the generator forward by thirteen steps in a single clock. As a CRC16 engine, each byte written to the high data register is folded into the register one bit per clock, most significant bit first.

A two-bit control field selects the mode. Code 00 runs the generator from reads. Code 01 requests one thirteen-step advance and then falls back to 00 by itself. Code 11 halts automatic stepping. Code 10 is reserved and a write of it changes nothing. Reads and writes use separate strobes and separate addresses, so one read and one write can fall in the same cycle.

Top module: `prng_crc16`

## Requirements
- R1: After reset the register holds 0x0000, the mode reads 00 and `busy` is low.
- R2: The register addresses are 0 for the low data byte, 1 for the high data byte and 2 for control. A write to address 0 while not busy moves register bits [7:0] into bits [15:8] and loads the written byte into bits [7:0]. Two such writes therefore seed all 16 bits.
- R3: While not busy, a read of address 0 returns register bits [7:0], and a read of address 1 returns bits [15:8]. A read of address 2 returns the mode in bits [1:0] with zeros above. A read of address 3 returns 0x00.
- R4: A single step shifts the register left by one and XORs in 0x8005 when the bit shifted out was 1. In mode 00, a read of address 1 while not busy, with no data write in the same cycle, returns the value before the step and applies 13 steps at that clock edge.
- R5: Writing code 01 makes the register advance by 13 steps at the first clock edge that is not busy and carries no data write. At that same edge the mode returns to 00, unless a control write in that cycle sets it.
- R6: A control write of code 10 leaves the mode unchanged. In mode 11, reads cause no step, while seeding writes and CRC writes still act.
- R7: A write to address 1 while not busy starts a CRC update of exactly 8 cycles, during which `busy` is high. Each cycle takes one data bit, MSB first: the register shifts left and XORs in 0x8005 when the outgoing bit differs from the data bit.
- R8: While busy, writes to address 0 or 1 are ignored, reads of address 0 or 1 return 0x00 and cause no step, and a pending code-01 advance waits.
- R9: When a data write is accepted in the same cycle as a read of address 1, the write acts and the read's step is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Write register address |
| wdata | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 2 | Read register address |
| rdata | output | 8 | Read data for `rd_addr` (combinational) |
| busy | output | 1 | CRC update in progress |

## Verification
Two pairs of functions can compete for the register in one cycle. A read of the high byte can step the generator while a seeding or CRC write loads the register. A pending single-step request can meet either a data write or an ongoing CRC update. The bench provokes both pairs directly: it raises a high-byte read together with a low-byte write, and it issues code 01 while a CRC byte is still being processed. Random traffic then mixes reads and writes on independent addresses. Every outcome is judged against a cycle-level bench model in which the write always wins and the step is either dropped (read) or deferred (single-step).

// File: rtl/prng_crc_pkg.sv
package prng_crc_pkg;

  typedef enum logic [1:0] {
    MODE_RUN  = 2'b00,
    MODE_ONCE = 2'b01,
    MODE_RSVD = 2'b10,
    MODE_HALT = 2'b11
  } mode_e;

  localparam logic [1:0] ADDR_LO  = 2'd0;
  localparam logic [1:0] ADDR_HI  = 2'd1;
  localparam logic [1:0] ADDR_CTL = 2'd2;

endpackage

// File: rtl/prng_rst_sync.sv
module prng_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/prng_unroll.sv
module prng_unroll #(
  parameter int          W     = 16,
  parameter logic [15:0] POLY  = 16'h8005,
  parameter int          STEPS = 13
) (
  input  logic [W-1:0] state_i,
  output logic [W-1:0] state_o
);
  logic [W-1:0] chain [0:STEPS];

  assign chain[0] = state_i;

  for (genvar g = 0; g < STEPS; g++) begin : g_step
    assign chain[g+1] = {chain[g][W-2:0], 1'b0} ^
                        (chain[g][W-1] ? POLY[W-1:0] : '0);
  end

  assign state_o = chain[STEPS];
endmodule

// File: rtl/prng_crc_shifter.sv
module prng_crc_shifter #(
  parameter int          W    = 16,
  parameter logic [15:0] POLY = 16'h8005,
  parameter int          BW   = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [BW-1:0] byte_i,
  input  logic [W-1:0]  state_i,
  output logic [W-1:0]  state_o,
  output logic          busy_o
);
  localparam int CW = $clog2(BW + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [BW-1:0] sh_q, sh_d;
  logic          en;
  logic          fb;

  assign busy_o = (cnt_q != '0);
  assign fb     = state_i[W-1] ^ sh_q[BW-1];
  assign state_o = {state_i[W-2:0], 1'b0} ^ (fb ? POLY[W-1:0] : '0);

  always_comb begin
    cnt_d = cnt_q;
    sh_d  = sh_q;
    en    = 1'b0;
    if (busy_o) begin
      en    = 1'b1;
      cnt_d = cnt_q - 1'b1;
      sh_d  = {sh_q[BW-2:0], 1'b0};
    end else if (start_i) begin
      en    = 1'b1;
      cnt_d = CW'(BW);
      sh_d  = byte_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (en) begin
      cnt_q <= cnt_d;
      sh_q  <= sh_d;
    end
  end
endmodule

// File: rtl/prng_mode_ctl.sv
module prng_mode_ctl
  import prng_crc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_wr_i,
  input  logic [1:0] code_i,
  input  logic       once_fire_i,
  output mode_e      mode_o
);
  mode_e mode_q, mode_d;
  logic  en;

  always_comb begin
    mode_d = mode_q;
    en     = 1'b0;
    if (ctl_wr_i && (code_i != MODE_RSVD)) begin
      en     = 1'b1;
      mode_d = mode_e'(code_i);
    end else if (once_fire_i) begin
      en     = 1'b1;
      mode_d = MODE_RUN;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  mode_q <= MODE_RUN;
    else if (en) mode_q <= mode_d;
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/prng_crc16.sv
module prng_crc16
  import prng_crc_pkg::*;
#(
  parameter int          W     = 16,
  parameter int          BW    = 8,
  parameter logic [15:0] POLY  = 16'h8005,
  parameter int          STEPS = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [BW-1:0] wdata,
  input  logic          rd_en,
  input  logic [1:0]    rd_addr,
  output logic [BW-1:0] rdata,
  output logic          busy
);
  logic          rst_sync_n;
  logic [W-1:0]  lfsr_q, lfsr_d;
  logic          lfsr_en;
  logic [W-1:0]  unrolled;
  logic [W-1:0]  crc_next;
  logic          acc_lo, acc_hi, acc_data;
  logic          run_step, once_step;
  logic          ctl_wr;
  mode_e         mode_q;

  prng_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign acc_lo   = wr_en && (wr_addr == ADDR_LO) && !busy;
  assign acc_hi   = wr_en && (wr_addr == ADDR_HI) && !busy;
  assign acc_data = acc_lo || acc_hi;
  assign ctl_wr   = wr_en && (wr_addr == ADDR_CTL);
  assign run_step = rd_en && (rd_addr == ADDR_HI) && !busy && !acc_data &&
                    (mode_q == MODE_RUN);
  assign once_step = (mode_q == MODE_ONCE) && !busy && !acc_data;

  prng_unroll #(.W(W), .POLY(POLY), .STEPS(STEPS)) u_unroll (
    .state_i (lfsr_q),
    .state_o (unrolled)
  );

  prng_crc_shifter #(.W(W), .POLY(POLY), .BW(BW)) u_crc (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .start_i (acc_hi),
    .byte_i  (wdata),
    .state_i (lfsr_q),
    .state_o (crc_next),
    .busy_o  (busy)
  );

  prng_mode_ctl u_mode (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .ctl_wr_i    (ctl_wr),
    .code_i      (wdata[1:0]),
    .once_fire_i (once_step),
    .mode_o      (mode_q)
  );

  always_comb begin
    lfsr_d  = lfsr_q;
    lfsr_en = 1'b0;
    if (busy) begin
      lfsr_en = 1'b1;
      lfsr_d  = crc_next;
    end else if (acc_lo) begin
      lfsr_en = 1'b1;
      lfsr_d  = {lfsr_q[W-BW-1:0], wdata};
    end else if (run_step || once_step) begin
      lfsr_en = 1'b1;
      lfsr_d  = unrolled;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  lfsr_q <= '0;
    else if (lfsr_en) lfsr_q <= lfsr_d;
  end

  always_comb begin
    rdata = '0;
    case (rd_addr)
      ADDR_LO:  if (!busy) rdata = lfsr_q[BW-1:0];
      ADDR_HI:  if (!busy) rdata = lfsr_q[W-1:W-BW];
      ADDR_CTL: rdata = {{(BW-2){1'b0}}, mode_q};
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/prng_crc16_chk.sv
module prng_crc16_chk
  import prng_crc_pkg::*;
#(
  parameter int W  = 16,
  parameter int BW = 8
) (
  input logic          clk,
  input logic          rst_sync_n,
  input logic          wr_en,
  input logic [1:0]    wr_addr,
  input logic [BW-1:0] wdata,
  input logic          rd_en,
  input logic [1:0]    rd_addr,
  input logic [BW-1:0] rdata,
  input logic          busy,
  input logic [W-1:0]  lfsr_q,
  input mode_e         mode_q
);
  logic [7:0] run_len;
  logic       data_wr;

  assign data_wr = wr_en && (wr_addr == ADDR_LO || wr_addr == ADDR_HI);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)   run_len <= '0;
    else if (busy)     run_len <= run_len + 1'b1;
    else               run_len <= '0;
  end

  assert_lo_shift_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!busy && wr_en && wr_addr == ADDR_LO) |=>
      lfsr_q == {$past(lfsr_q[W-BW-1:0]), $past(wdata)});

  assert_crc_start_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!busy && wr_en && wr_addr == ADDR_HI) |=> busy);

  assert_crc_len_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(busy) |-> run_len == 8'(BW));

  assert_halt_stable_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode_q == MODE_HALT && !busy && !data_wr) |=> $stable(lfsr_q));

  assert_no_rsvd_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mode_q != MODE_RSVD);

  assert_once_clear_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode_q == MODE_ONCE && !busy && !wr_en) |=> mode_q == MODE_RUN);

  assert_busy_read_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (busy && rd_en && (rd_addr == ADDR_LO || rd_addr == ADDR_HI)) |-> rdata == '0);
endmodule

bind prng_crc16 prng_crc16_chk #(.W(W), .BW(BW)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .wdata      (wdata),
  .rd_en      (rd_en),
  .rd_addr    (rd_addr),
  .rdata      (rdata),
  .busy       (busy),
  .lfsr_q     (lfsr_q),
  .mode_q     (mode_q)
);

// File: tb/prng_crc16_tb_top.sv
`timescale 1ns/1ps
module prng_crc16_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic       rd_en = 1'b0;
  logic [1:0] rd_addr = 2'd0;
  logic [7:0] rdata;
  logic       busy;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [15:0] m_lfsr;
  logic [1:0]  m_mode;
  int          m_cnt;
  logic [7:0]  m_sh;

  always #5 clk = ~clk;

  prng_crc16 dut_i (
    .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_addr (wr_addr),
    .wdata (wdata), .rd_en (rd_en), .rd_addr (rd_addr),
    .rdata (rdata), .busy (busy)
  );

  function automatic logic [15:0] bit_step(logic [15:0] s, logic d);
    logic fb;
    fb = s[15] ^ d;
    s  = {s[14:0], 1'b0};
    if (fb) s = s ^ 16'h8005;
    return s;
  endfunction

  function automatic logic [15:0] step13(logic [15:0] s);
    for (int i = 0; i < 13; i++) s = bit_step(s, 1'b0);
    return s;
  endfunction

  function automatic logic [7:0] exp_read(logic [1:0] a);
    if (a == 2'd2) return {6'b0, m_mode};
    if (a == 2'd3 || m_cnt != 0) return 8'h00;
    return (a == 2'd0) ? m_lfsr[7:0] : m_lfsr[15:8];
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, check before edge, update model at edge
  task automatic cyc(bit wr, logic [1:0] wa, logic [7:0] wd,
                     bit rd, logic [1:0] ra, string tag);
    bit mbusy, acc_lo, acc_hi, once;
    wr_en = wr; wr_addr = wa; wdata = wd; rd_en = rd; rd_addr = ra;
    #1;
    check("R7 busy", {15'b0, busy}, {15'b0, (m_cnt != 0)});
    if (rd) check(tag, {8'h0, rdata}, {8'h0, exp_read(ra)});
    @(posedge clk);
    mbusy  = (m_cnt != 0);
    acc_lo = wr && wa == 2'd0 && !mbusy;
    acc_hi = wr && wa == 2'd1 && !mbusy;
    once   = 1'b0;
    if (mbusy) begin
      m_lfsr = bit_step(m_lfsr, m_sh[7]);
      m_sh   = {m_sh[6:0], 1'b0};
      m_cnt--;
    end else if (acc_lo) begin
      m_lfsr = {m_lfsr[7:0], wd};
    end else if (acc_hi) begin
      m_sh = wd; m_cnt = 8;
    end else if (rd && ra == 2'd1 && m_mode == 2'b00) begin
      m_lfsr = step13(m_lfsr);
    end else if (m_mode == 2'b01) begin
      m_lfsr = step13(m_lfsr); once = 1'b1;
    end
    if (wr && wa == 2'd2 && wd[1:0] != 2'b10) m_mode = wd[1:0];
    else if (once) m_mode = 2'b00;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    cyc(1'b1, a, d, 1'b0, 2'd0, "");
  endtask
  task automatic rd(logic [1:0] a, string tag);
    cyc(1'b0, 2'd0, 8'h00, 1'b1, a, tag);
  endtask
  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 2'd0, 8'h00, 1'b0, 2'd0, "");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    m_lfsr = 16'h0; m_mode = 2'b00; m_cnt = 0; m_sh = 8'h0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd(2'd0, "R1 reset low");
    rd(2'd2, "R1 reset mode");
    rd(2'd1, "R1 reset high");
    // R2 seeding, R3 readback
    wr(2'd0, 8'h5A); wr(2'd0, 8'hC3);
    rd(2'd0, "R2 seed low");
    rd(2'd3, "R3 unused addr");
    rd(2'd1, "R3 seed high");
    // R4 normal stepping
    rd(2'd1, "R4 stepped high");
    rd(2'd0, "R4 stepped low");
    // R6 halt mode and reserved code
    wr(2'd2, 8'h03);
    rd(2'd1, "R6 halt high"); rd(2'd1, "R6 halt high again");
    wr(2'd2, 8'h02);
    rd(2'd2, "R6 reserved ignored");
    wr(2'd0, 8'h11);
    rd(2'd0, "R6 seed in halt");
    // R5 single step
    wr(2'd2, 8'h01);
    idle(1);
    rd(2'd2, "R5 mode back to run");
    rd(2'd0, "R5 once low");
    // R7 CRC, R8 ignore during busy
    wr(2'd0, 8'hFF); wr(2'd0, 8'hFF);
    wr(2'd1, 8'h31);
    wr(2'd0, 8'h99);
    rd(2'd0, "R8 busy low read");
    rd(2'd1, "R8 busy high read");
    wr(2'd2, 8'h01);
    idle(6);
    rd(2'd2, "R8 once pending after busy");
    rd(2'd0, "R7 crc low");
    rd(2'd1, "R7 crc high");
    // R9 collision: high read with low write
    cyc(1'b1, 2'd0, 8'hA7, 1'b1, 2'd1, "R9 read in collision");
    rd(2'd0, "R9 write won");
    rd(2'd1, "R9 no step");
    // random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [1:0] wa, ra, code;
      bit w, r;
      w  = ($urandom % 3) == 0;
      r  = ($urandom % 2) == 0;
      wa = 2'($urandom % 3);
      ra = 2'($urandom % 4);
      code = 2'($urandom % 4);
      if (wa == 2'd2 && code == 2'b11 && ($urandom % 4) != 0) code = 2'b00;
      cyc(w, wa, (wa == 2'd2) ? {6'b0, code} : 8'($urandom), r, ra,
          "R4 random read");
    end
    idle(10);
    rd(2'd0, "R3 final low");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule